// File: doc/BRIEF.md
# Multi-core reset and boot controller

This block is a small register file on a 32-bit word bus that governs the start, stop and reset of up to four processor cores, and the software reset of two peripheral subsystems. Software writes a boot entry address and a context argument for each secondary core into a pair of general registers. It then flips bits in a control register.

Each write to the control register is compared against the stored value, and only the bits that change produce actions. Actions are one-cycle request pulses per core: power-on, power-off or reset. A power-on pulse carries the entry address and argument from that core's register pair.

Reset request bits stay set in the control register until the addressed core answers with a one-cycle done strobe. The subsystem reset bits clear themselves in the same write.

Top module: `core_boot_ctl`

## Requirements
- R1: The register index is `bus_addr >> 2`; twelve registers exist (indexes 0..11). A write to an index other than 0 stores the data unchanged, and `bus_rdata` shows the addressed register combinationally; writes take effect at the clock edge.
- R2: A read of an index of 12 or more returns zero; a write to such an index changes no register and raises no request.
- R3: After reset, index 0 (control) reads 0x0000_0521, index 1 (reset status) reads 0x1, index 2 (interrupt mask) reads 0x1F, and every other register reads 0.
- R4: A control write acts only on bits that differ between the stored and the written value; rewriting the stored value raises no request.
- R5: Control bits 22, 23 and 24 enable cores 1, 2 and 3. A 0-to-1 flip pulses `pwr_on_req[c]` with `boot_entry`/`boot_arg` lane c loaded from index 6+2(c-1) (entry) and 7+2(c-1) (argument). A 1-to-0 flip pulses `pwr_off_req[c]`. Lanes not being powered on carry zero, and lane 0 always carries zero.
- R6: When a core's enable bit flips, a flip of that same core's reset bit in the same write raises no reset request. The reset bit is still stored as written.
- R7: Control bits 13..16 are the reset requests of cores 0..3. Any flip of one pulses `core_rst_req[c]` for exactly one cycle, in the cycle after the write, and the bit keeps its written value.
- R8: `core_done[c]` clears control bit 13+c at the next edge. If it coincides with a control write, the write is applied first and the clear second.
- R9: Control bits 4 and 12 are the subsystem 1 and 2 software resets. A flip pulses `sub_rst_req[0]` or `sub_rst_req[1]`, and the bit is stored as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| core_done | input | NCORES | Per-core completion strobe |
| pwr_on_req | output | NCORES | Per-core start pulse |
| pwr_off_req | output | NCORES | Per-core stop pulse |
| core_rst_req | output | NCORES | Per-core reset pulse |
| boot_entry | output | 32*NCORES | Entry address per core lane, valid with start pulse |
| boot_arg | output | 32*NCORES | Context argument per core lane, valid with start pulse |
| sub_rst_req | output | 2 | Subsystem software reset pulses |

## Verification
Read data is due in the same cycle as the address, so the bench samples it shortly after driving the address. A write becomes visible on reads from the following edge. Request pulses and their payload appear one edge after the write and drop one edge later. The bench therefore drives at a falling edge, samples pulses at the next falling edge, and confirms they are gone at the one after. Done strobes are followed by a readback one edge later, matching the order in which a coinciding write and clear are applied.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
   localparam int unsigned DW        = 32;
   localparam int unsigned CTRL_IDX  = 0;
   localparam int unsigned STAT_IDX  = 1;
   localparam int unsigned MASK_IDX  = 2;
   localparam int unsigned BOOT_BASE = 6;
   localparam int unsigned SUB1_BIT  = 4;
   localparam int unsigned SUB2_BIT  = 12;
   localparam int unsigned CRST_LO   = 13;
   localparam int unsigned CEN_LO    = 22;
   localparam logic [DW-1:0] CTRL_INIT = 32'h0000_0521;
   localparam logic [DW-1:0] STAT_INIT = 32'h0000_0001;
   localparam logic [DW-1:0] MASK_INIT = 32'h0000_001F;

   function automatic logic [DW-1:0] init_of(input int unsigned idx);
      if (idx == CTRL_IDX) return CTRL_INIT;
      if (idx == STAT_IDX) return STAT_INIT;
      if (idx == MASK_IDX) return MASK_INIT;
      return '0;
   endfunction
endpackage

// File: rtl/cbc_regs.sv
module cbc_regs
   import cbc_pkg::*;
#(
   parameter int unsigned NREGS = 12,
   parameter int unsigned IDX_W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_ok,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [DW-1:0]       wr_data,
   input  logic [DW-1:0]       ctrl_wval,
   input  logic [DW-1:0]       ctrl_clr,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [DW-1:0]       rd_data,
   output logic [NREGS*DW-1:0] regs_flat
);
   generate
      for (genvar i = 0; i < NREGS; i++) begin : g_reg
         localparam logic [DW-1:0] INIT = init_of(i);
         logic [DW-1:0] q;
         logic          hit;
         assign hit = wr_ok && (wr_idx == IDX_W'(i));
         if (i == CTRL_IDX) begin : g_ctrl
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= INIT;
               else        q <= (hit ? ctrl_wval : q) & ~ctrl_clr;
            end
         end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   q <= INIT;
               else if (hit) q <= wr_data;
            end
         end
         assign regs_flat[i*DW +: DW] = q;
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREGS; i++)
         if (rd_idx == IDX_W'(i)) rd_data = regs_flat[i*DW +: DW];
   end
endmodule

// File: rtl/cbc_ctrl_eval.sv
module cbc_ctrl_eval
   import cbc_pkg::*;
#(
   parameter int unsigned NCORES = 4
) (
   input  logic              wr,
   input  logic [DW-1:0]     old_v,
   input  logic [DW-1:0]     new_v,
   output logic [DW-1:0]     store_v,
   output logic [NCORES-1:0] on_m,
   output logic [NCORES-1:0] off_m,
   output logic [NCORES-1:0] rst_m,
   output logic [1:0]        sub_m
);
   logic [DW-1:0]     chg;
   logic [NCORES-1:0] en_chg;

   assign chg = wr ? (old_v ^ new_v) : '0;

   assign en_chg[0] = 1'b0;
   assign on_m[0]   = 1'b0;
   assign off_m[0]  = 1'b0;

   generate
      for (genvar c = 1; c < NCORES; c++) begin : g_en
         assign en_chg[c] = chg[CEN_LO+c-1];
         assign on_m[c]   = en_chg[c] &  new_v[CEN_LO+c-1];
         assign off_m[c]  = en_chg[c] & ~new_v[CEN_LO+c-1];
      end
      for (genvar c = 0; c < NCORES; c++) begin : g_rst
         assign rst_m[c] = chg[CRST_LO+c] & ~en_chg[c];
      end
   endgenerate

   assign sub_m = {chg[SUB2_BIT], chg[SUB1_BIT]};

   always_comb begin
      store_v           = new_v;
      store_v[SUB1_BIT] = new_v[SUB1_BIT] & ~chg[SUB1_BIT];
      store_v[SUB2_BIT] = new_v[SUB2_BIT] & ~chg[SUB2_BIT];
   end
endmodule

// File: rtl/cbc_pulse_out.sv
module cbc_pulse_out
   import cbc_pkg::*;
#(
   parameter int unsigned NCORES = 4,
   parameter int unsigned NREGS  = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NCORES-1:0]    on_m,
   input  logic [NCORES-1:0]    off_m,
   input  logic [NCORES-1:0]    rst_m,
   input  logic [1:0]           sub_m,
   input  logic [NREGS*DW-1:0]  regs_flat,
   output logic [NCORES-1:0]    pwr_on_req,
   output logic [NCORES-1:0]    pwr_off_req,
   output logic [NCORES-1:0]    core_rst_req,
   output logic [1:0]           sub_rst_req,
   output logic [NCORES*DW-1:0] boot_entry,
   output logic [NCORES*DW-1:0] boot_arg
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_on_req   <= '0;
         pwr_off_req  <= '0;
         core_rst_req <= '0;
         sub_rst_req  <= '0;
      end else begin
         pwr_on_req   <= on_m;
         pwr_off_req  <= off_m;
         core_rst_req <= rst_m;
         sub_rst_req  <= sub_m;
      end
   end

   generate
      for (genvar c = 0; c < NCORES; c++) begin : g_lane
         if (c == 0) begin : g_boot0
            assign boot_entry[0 +: DW] = '0;
            assign boot_arg[0 +: DW]   = '0;
         end else begin : g_bootn
            localparam int unsigned EI = BOOT_BASE + 2*(c-1);
            localparam int unsigned AI = EI + 1;
            logic [DW-1:0] e_q, a_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  e_q <= '0;
                  a_q <= '0;
               end else if (on_m[c]) begin
                  e_q <= regs_flat[EI*DW +: DW];
                  a_q <= regs_flat[AI*DW +: DW];
               end else begin
                  e_q <= '0;
                  a_q <= '0;
               end
            end
            assign boot_entry[c*DW +: DW] = e_q;
            assign boot_arg[c*DW +: DW]   = a_q;
         end
      end
   endgenerate
endmodule

// File: rtl/core_boot_ctl.sv
module core_boot_ctl
   import cbc_pkg::*;
#(
   parameter int unsigned NCORES = 4,
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned NREGS  = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [NCORES-1:0]    core_done,
   output logic [NCORES-1:0]    pwr_on_req,
   output logic [NCORES-1:0]    pwr_off_req,
   output logic [NCORES-1:0]    core_rst_req,
   output logic [NCORES*32-1:0] boot_entry,
   output logic [NCORES*32-1:0] boot_arg,
   output logic [1:0]           sub_rst_req
);
   localparam int unsigned IDX_W    = ADDR_W - 2;
   localparam int unsigned MIN_REGS = BOOT_BASE + 2*(NCORES-1);
   localparam logic [IDX_W:0] REG_LIM = (IDX_W+1)'(NREGS);

   initial begin
      if (NCORES < 2 || NCORES > 4)     $fatal(1, "NCORES must be 2..4");
      if (ADDR_W < 3)                   $fatal(1, "ADDR_W too small");
      if (NREGS < MIN_REGS)             $fatal(1, "NREGS too small for boot pairs");
      if (NREGS > (1 << IDX_W))         $fatal(1, "NREGS exceeds window");
   end

   logic [IDX_W-1:0]    idx;
   logic                in_rng, wr_ok, ctrl_wr;
   logic [DW-1:0]       ctrl_q, ctrl_wval, clr_mask;
   logic [NREGS*DW-1:0] regs_flat;
   logic [NCORES-1:0]   on_m, off_m, rst_m;
   logic [1:0]          sub_m;
   logic [DW-1:0]       rd_raw;

   assign idx     = bus_addr[ADDR_W-1:2];
   assign in_rng  = {1'b0, idx} < REG_LIM;
   assign wr_ok   = bus_sel & bus_we & in_rng;
   assign ctrl_wr = wr_ok & (idx == IDX_W'(CTRL_IDX));
   assign ctrl_q  = regs_flat[CTRL_IDX*DW +: DW];

   always_comb begin
      clr_mask = '0;
      for (int c = 0; c < NCORES; c++) clr_mask[CRST_LO+c] = core_done[c];
   end

   cbc_ctrl_eval #(.NCORES(NCORES)) u_eval (
      .wr(ctrl_wr), .old_v(ctrl_q), .new_v(bus_wdata), .store_v(ctrl_wval),
      .on_m(on_m), .off_m(off_m), .rst_m(rst_m), .sub_m(sub_m)
   );

   cbc_regs #(.NREGS(NREGS), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_idx(idx), .wr_data(bus_wdata),
      .ctrl_wval(ctrl_wval), .ctrl_clr(clr_mask), .rd_idx(idx), .rd_data(rd_raw),
      .regs_flat(regs_flat)
   );

   assign bus_rdata = in_rng ? rd_raw : '0;

   cbc_pulse_out #(.NCORES(NCORES), .NREGS(NREGS)) u_out (
      .clk(clk), .rst_n(rst_n), .on_m(on_m), .off_m(off_m), .rst_m(rst_m),
      .sub_m(sub_m), .regs_flat(regs_flat), .pwr_on_req(pwr_on_req),
      .pwr_off_req(pwr_off_req), .core_rst_req(core_rst_req),
      .sub_rst_req(sub_rst_req), .boot_entry(boot_entry), .boot_arg(boot_arg)
   );
endmodule

// File: rtl/core_boot_ctl_chk.sv
module core_boot_ctl_chk
   import cbc_pkg::*;
#(
   parameter int unsigned NCORES = 4,
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned NREGS  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [NCORES-1:0] core_done,
   input logic [NCORES-1:0] pwr_on_req,
   input logic [NCORES-1:0] pwr_off_req,
   input logic [NCORES-1:0] core_rst_req,
   input logic [1:0]        sub_rst_req,
   input logic [DW-1:0]     ctrl_q
);
   logic          ctl_write;
   logic [DW-1:0] done_bits;

   assign ctl_write = bus_sel & bus_we & (bus_addr[ADDR_W-1:2] == '0);

   always_comb begin
      done_bits = '0;
      for (int c = 0; c < NCORES; c++) done_bits[CRST_LO+c] = core_done[c];
   end

   a_r5_on_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      ((|pwr_on_req) || (|pwr_off_req)) |-> $past(ctl_write));

   a_r5_on_off_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_on_req & pwr_off_req) == '0);

   a_r6_enable_masks_reset: assert property (@(posedge clk) disable iff (!rst_n)
      ((pwr_on_req | pwr_off_req) & core_rst_req) == '0);

   a_r7_rst_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|core_rst_req) |-> $past(ctl_write));

   a_r8_done_clears_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (|core_done) |=> ((ctrl_q & $past(done_bits)) == '0));

   a_r9_sub_bits_stay_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[SUB1_BIT] == 1'b0) && (ctrl_q[SUB2_BIT] == 1'b0));

   a_r9_sub_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|sub_rst_req) |-> $past(ctl_write));
endmodule

bind core_boot_ctl core_boot_ctl_chk #(.NCORES(NCORES), .ADDR_W(ADDR_W), .NREGS(NREGS)) u_chk (.*);

// File: tb/core_boot_ctl_test.sv
module core_boot_ctl_test;
   localparam int NC = 4;
   localparam int AW = 12;
   localparam int NR = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NC-1:0] core_done = '0;
   logic [NC-1:0] pwr_on_req, pwr_off_req, core_rst_req;
   logic [NC*32-1:0] boot_entry, boot_arg;
   logic [1:0]    sub_rst_req;

   int n_chk = 0, n_bad = 0;
   logic [31:0] m_reg [NR];

   always #5 clk = ~clk;

   core_boot_ctl #(.NCORES(NC), .ADDR_W(AW), .NREGS(NR)) uut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   task automatic rd_chk(input int idx, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(idx*4);
      #1 chk(tag, bus_rdata, exp);
      bus_sel = 1'b0;
   endtask

   task automatic check_all(input string tag);
      for (int i = 0; i < NR; i++) rd_chk(i, m_reg[i], tag);
   endtask

   task automatic wr(input int idx, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(idx*4); bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
      if (idx < NR && idx != 0) m_reg[idx] = d;
   endtask

   task automatic quiet_chk(input string tag);
      chk({tag, " on"},  {28'b0, pwr_on_req},   '0);
      chk({tag, " off"}, {28'b0, pwr_off_req},  '0);
      chk({tag, " rst"}, {28'b0, core_rst_req}, '0);
      chk({tag, " sub"}, {30'b0, sub_rst_req},  '0);
   endtask

   // control write with expected actions computed from bit layout
   task automatic ctrl_wr(input logic [31:0] v, input logic [NC-1:0] done, input string tag);
      logic [31:0] chg, nv;
      logic [NC-1:0] e_on, e_off, e_rst;
      logic [1:0] e_sub;
      chg = m_reg[0] ^ v;
      e_on = '0; e_off = '0; e_rst = '0;
      for (int c = 1; c < NC; c++)
         if (chg[21+c]) begin
            if (v[21+c]) e_on[c] = 1'b1; else e_off[c] = 1'b1;
         end
      for (int c = 0; c < NC; c++)
         if (chg[13+c] && !(c > 0 && chg[21+c])) e_rst[c] = 1'b1;
      e_sub = {chg[12], chg[4]};
      nv = v;
      nv[4]  = v[4]  & ~chg[4];
      nv[12] = v[12] & ~chg[12];
      for (int c = 0; c < NC; c++) if (done[c]) nv[13+c] = 1'b0;
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = '0; bus_wdata = v; core_done = done;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; core_done = '0;
      chk({tag, " on"},  {28'b0, pwr_on_req},   {28'b0, e_on});
      chk({tag, " off"}, {28'b0, pwr_off_req},  {28'b0, e_off});
      chk({tag, " rst"}, {28'b0, core_rst_req}, {28'b0, e_rst});
      chk({tag, " sub"}, {30'b0, sub_rst_req},  {30'b0, e_sub});
      for (int c = 0; c < NC; c++) begin
         chk({tag, " entry"}, boot_entry[c*32 +: 32], e_on[c] ? m_reg[6+2*(c-1)] : 32'h0);
         chk({tag, " arg"},   boot_arg[c*32 +: 32],   e_on[c] ? m_reg[7+2*(c-1)] : 32'h0);
      end
      m_reg[0] = nv;
      #1 chk({tag, " store"}, bus_rdata, nv);
      @(posedge clk);
      @(negedge clk);
      quiet_chk({tag, " one-cycle R7"});
   endtask

   task automatic done_pulse(input logic [NC-1:0] d);
      @(negedge clk);
      core_done = d;
      @(posedge clk);
      @(negedge clk);
      core_done = '0;
      for (int c = 0; c < NC; c++) if (d[c]) m_reg[0][13+c] = 1'b0;
      rd_chk(0, m_reg[0], "R8 done clears reset bit");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      for (int i = 0; i < NR; i++) m_reg[i] = 32'h0;
      m_reg[0] = 32'h521; m_reg[1] = 32'h1; m_reg[2] = 32'h1F;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R3 reset values, quiet outputs
      check_all("R3 reset value");
      quiet_chk("R3 reset");

      // R2 out-of-range reads sweep
      for (int i = NR; i < 1024; i++) rd_chk(i, 32'h0, "R2 out-of-range read");

      // R1 plain store and readback over all non-control indexes
      for (int i = 1; i < NR; i++) wr(i, 32'hA5000000 + 32'(i * 32'h01010101));
      check_all("R1 plain store");

      // R2 out-of-range writes discarded
      wr(NR, 32'hDEADBEEF);
      wr(1023, 32'hCAFEF00D);
      quiet_chk("R2 no request");
      check_all("R2 write discarded");

      // boot pairs with distinct values
      for (int c = 1; c < NC; c++) begin
         wr(6+2*(c-1), 32'h8000_0000 + 32'(c * 32'h1000));
         wr(7+2*(c-1), 32'h0000_00C0 + 32'(c));
      end

      // R5 sweep enable patterns (on and off transitions)
      for (int p = 0; p < 8; p++)
         ctrl_wr((m_reg[0] & ~32'h01C0_0000) | (32'(p) << 22), '0, "R5 enable sweep");
      ctrl_wr(m_reg[0] & ~32'h01C0_0000, '0, "R5 all off");

      // R4 rewrite of stored value
      ctrl_wr(m_reg[0], '0, "R4 no change");

      // R7 reset-bit flip sweep, with R8 done clearing afterwards
      for (int p = 1; p < 16; p++) begin
         ctrl_wr(m_reg[0] ^ (32'(p) << 13), '0, "R7 reset flip");
         done_pulse(NC'(p));
      end

      // R6 enable flip masks same-core reset flip
      ctrl_wr(m_reg[0] | (32'h1 << 22) | (32'h1 << 14) | (32'h1 << 15), '0, "R6 masked reset");
      rd_chk(0, m_reg[0], "R6 reset bit stored");
      done_pulse(4'b0010);
      ctrl_wr(m_reg[0] & ~(32'h1 << 22), '0, "R6 core1 off");

      // R8 write and done in the same cycle
      ctrl_wr(m_reg[0] | (32'h1 << 13), 4'b0001, "R8 same-cycle done");
      ctrl_wr(m_reg[0] | (32'h1 << 16) | (32'h1 << 24), 4'b1000, "R8 same-cycle with enable");
      done_pulse(4'b1111);

      // R9 subsystem resets
      ctrl_wr(m_reg[0] | (32'h1 << 4), '0, "R9 sub1");
      ctrl_wr(m_reg[0] | (32'h1 << 12), '0, "R9 sub2");
      ctrl_wr(m_reg[0] | (32'h1 << 4) | (32'h1 << 12), '0, "R9 both");

      check_all("R1 final state");
      finish_run();
   end
endmodule